// File: doc/BRIEF.md
# Wake and Sleep Mode Controller

This block gates the counting logic of a battery charge monitor. It watches three things: a flag from an analog comparator that is high while the sensed current signal is above the wake threshold, the level of the single-wire host data line, and a once-per-second strobe. It produces `count_enable` for the counter blocks and an active-low `wake_n` output that is pulled low while the part is fully operating.

Going to sleep takes two conditions at once. The sense signal must be under the threshold and the host line must be low, and both must hold for more than ten seconds. Leaving sleep takes one condition: the host line going high. A sense signal that rises above threshold during sleep does not wake the block. The host line is asynchronous, so it passes through a two-flop synchronizer. The threshold flag and the strobe are taken to be synchronous to `clk`. `rst_n` resets asynchronously and is expected to be released in step with `clk`.

Top module: `wake_sleep_ctrl`

## Requirements
- R1: After reset the block is in the run mode (`count_enable` = 1) and the dwell timer is cleared, so a full run of qualifying strobes is needed before sleep.
- R2: `wake_n` is 0 exactly when the block is in run mode, `above_thr` is 1 and the synchronized host line is 1. Otherwise `wake_n` is 1.
- R3: In run mode, the 11th consecutive `sec_tick` pulse with `above_thr` = 0 and the synchronized host line at 0 puts the block to sleep. `count_enable` reads 0 from the next clock cycle on.
- R4: If `above_thr` goes to 1 or the synchronized host line goes to 1 before that 11th pulse, the dwell count restarts from zero.
- R5: While asleep, `count_enable` is 0 and `wake_n` is 1.
- R6: While asleep, `above_thr` = 1 and `sec_tick` pulses have no effect. The block stays asleep as long as the synchronized host line is 0.
- R7: A 1 on the synchronized host line during sleep brings the block back to run mode on the next clock edge. From a change at `host_line`, `count_enable` returns to 1 after the third rising clock edge.
- R8: `host_line` reaches the mode logic through two flip-flops. A change at the pin shows up on `wake_n` after exactly two rising clock edges.
- R9: `sec_tick` pulses in run mode while `above_thr` = 1 or the host line is 1 do not advance the dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_line | input | 1 | Level of the single-wire host data line, asynchronous |
| above_thr | input | 1 | Comparator flag: sense signal above wake threshold |
| sec_tick | input | 1 | One-cycle strobe once per second |
| count_enable | output | 1 | High while counters may run |
| wake_n | output | 1 | Active-low wake indication, low in full operating state |

## Verification
The hardest case to reach from the ports is the tenth-versus-eleventh strobe boundary, combined with a disturbance that lands just before it. Here a one-cycle host pulse must reset the dwell count even though it has to pass two synchronizer stages before it becomes visible. The stimulus gives exactly ten qualifying strobes, then a short host or threshold excursion, then ten more strobes. It checks that the block is still running, and only then gives the eleventh strobe of an undisturbed run. A reference model in the bench tracks the pipeline delay with plain integers and is compared on every cycle. Sleep exit is probed cycle by cycle across the synchronizer latency.

// File: rtl/wake_sleep_pkg.sv
package wake_sleep_pkg;

  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } mode_e;

  // Width able to hold 0..limit inclusive, at least one bit.
  function automatic int unsigned dwell_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/wake_line_sync.sv
module wake_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/wake_dwell_timer.sv
module wake_dwell_timer #(
  parameter int unsigned LIMIT = 10,
  parameter int unsigned W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         expire
);

  localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_limit;

  assign at_limit = (cnt_q == LIMIT_V);

  always_comb begin
    cnt_en = clear | tick;
    cnt_d  = cnt_q;
    if (clear)         cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = tick & ~clear & at_limit;
  assign count  = cnt_q;

endmodule

// File: rtl/wake_mode_fsm.sv
module wake_mode_fsm
  import wake_sleep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dwell_expire,
  input  logic  host_high,
  output mode_e mode
);

  mode_e mode_q;
  mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:   if (dwell_expire) mode_d = MODE_SLEEP;
      MODE_SLEEP: if (host_high)    mode_d = MODE_RUN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

endmodule

// File: rtl/wake_sleep_ctrl.sv
module wake_sleep_ctrl
  import wake_sleep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SLEEP_SECONDS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_line,
  input  logic above_thr,
  input  logic sec_tick,
  output logic count_enable,
  output logic wake_n
);

  localparam int unsigned DW = dwell_width(SLEEP_SECONDS);

  logic          host_s;
  logic          idle_cond;
  logic          dwell_clear;
  logic          dwell_expire;
  logic [DW-1:0] dwell_cnt;
  mode_e         mode;
  logic          running;

  wake_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (host_line),
    .sync_out (host_s)
  );

  assign idle_cond   = ~host_s & ~above_thr;
  assign running     = (mode == MODE_RUN);
  assign dwell_clear = ~idle_cond | ~running;

  wake_dwell_timer #(.LIMIT(SLEEP_SECONDS), .W(DW)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (dwell_clear),
    .tick   (sec_tick),
    .count  (dwell_cnt),
    .expire (dwell_expire)
  );

  wake_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .dwell_expire (dwell_expire),
    .host_high    (host_s),
    .mode         (mode)
  );

  assign count_enable = running;
  assign wake_n       = ~(running & above_thr & host_s);

endmodule

// File: rtl/wake_sleep_checker.sv
module wake_sleep_checker #(
  parameter int unsigned SLEEP_SECONDS = 10,
  parameter int unsigned DW            = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_line,
  input logic          above_thr,
  input logic          sec_tick,
  input logic          count_enable,
  input logic          wake_n,
  input logic          host_s,
  input logic [DW-1:0] dwell_cnt
);

  localparam logic [DW-1:0] LIM = DW'(SLEEP_SECONDS);

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= 2'd0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  assert_sleep_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !count_enable |-> wake_n);

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_enable && sec_tick && !above_thr && !host_s && dwell_cnt == LIM) |=> !count_enable);

  assert_sleep_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(count_enable) |-> $past(sec_tick && !above_thr && !host_s));

  assert_stay_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_enable && !host_s) |=> !count_enable);

  assert_exit_by_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_enable) |-> $past(host_s));

  assert_dwell_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (above_thr || host_s) |=> (dwell_cnt == '0));

  assert_dwell_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_cnt <= LIM);

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (host_s == $past(host_line, 2)));

endmodule

bind wake_sleep_ctrl wake_sleep_checker #(
  .SLEEP_SECONDS (SLEEP_SECONDS),
  .DW            (DW)
) u_wake_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_line    (host_line),
  .above_thr    (above_thr),
  .sec_tick     (sec_tick),
  .count_enable (count_enable),
  .wake_n       (wake_n),
  .host_s       (host_s),
  .dwell_cnt    (dwell_cnt)
);

// File: tb/wake_sleep_ctrl_test.sv
`timescale 1ns/1ps
module wake_sleep_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_line = 1'b0;
  logic above_thr = 1'b0;
  logic sec_tick = 1'b0;
  logic count_enable;
  logic wake_n;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_sleep_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_line    (host_line),
    .above_thr    (above_thr),
    .sec_tick     (sec_tick),
    .count_enable (count_enable),
    .wake_n       (wake_n)
  );

  // Behavioural reference: integers for the two-edge host delay,
  // a seconds tally and an asleep flag.
  int m_h1, m_h2, m_secs;
  bit m_asleep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h1 = 0; m_h2 = 0; m_secs = 0; m_asleep = 0;
    end else begin
      if (m_asleep) begin
        m_secs = 0;
        if (m_h2 == 1) m_asleep = 0;
      end else if (m_h2 == 1 || above_thr) begin
        m_secs = 0;
      end else if (sec_tick) begin
        if (m_secs == 10) begin m_asleep = 1; m_secs = 0; end
        else m_secs = m_secs + 1;
      end
      m_h2 = m_h1;
      m_h1 = host_line ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_ce, exp_wn;
      exp_ce = !m_asleep;
      exp_wn = !(!m_asleep && above_thr && m_h2 == 1);
      n_checks++;
      if (count_enable !== exp_ce) begin
        n_fail++;
        $display("FAIL R3/R6/R7 model count_enable actual=%b expected=%b t=%0t", count_enable, exp_ce, $time);
      end
      n_checks++;
      if (wake_n !== exp_wn) begin
        n_fail++;
        $display("FAIL R2/R5 model wake_n actual=%b expected=%b t=%0t", wake_n, exp_wn, $time);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 sec_tick = 1'b1;
      @(negedge clk); #1 sec_tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    check("R1 reset count_enable", count_enable, 1'b1);
    check("R1 reset wake_n", wake_n, 1'b1);
    rst_n = 1'b1;
    step(2);

    // R2 and R8: full operating state and synchronizer latency
    host_line = 1'b1; above_thr = 1'b1;
    step(1);
    check("R8 one edge after host rise wake_n", wake_n, 1'b1);
    step(1);
    check("R8 two edges after host rise wake_n", wake_n, 1'b0);
    check("R2 full operation wake_n", wake_n, 1'b0);
    above_thr = 1'b0; #1;
    check("R2 below threshold wake_n", wake_n, 1'b1);
    above_thr = 1'b1; #1;
    host_line = 1'b0;
    step(1);
    check("R8 one edge after host fall wake_n", wake_n, 1'b0);
    step(1);
    check("R8 two edges after host fall wake_n", wake_n, 1'b1);

    // R9: strobes while host high do not count
    host_line = 1'b1; above_thr = 1'b0;
    step(3);
    ticks(15);
    check("R9 host high strobes ignored", count_enable, 1'b1);
    host_line = 1'b0; above_thr = 1'b1;
    step(3);
    ticks(15);
    check("R9 above threshold strobes ignored", count_enable, 1'b1);

    // R4: restart by threshold excursion, then by a host pulse
    above_thr = 1'b0;
    step(3);
    ticks(10);
    check("R4 ten strobes still running", count_enable, 1'b1);
    above_thr = 1'b1; step(1); above_thr = 1'b0;
    ticks(10);
    check("R4 restart after threshold excursion", count_enable, 1'b1);
    host_line = 1'b1; step(1); host_line = 1'b0;
    step(3);
    ticks(10);
    check("R4 restart after host pulse", count_enable, 1'b1);

    // R3: eleventh strobe
    ticks(1);
    check("R3 eleventh strobe enters sleep", count_enable, 1'b0);
    check("R5 sleep wake_n", wake_n, 1'b1);

    // R6: threshold alone does not wake
    above_thr = 1'b1;
    step(5);
    ticks(12);
    check("R6 above threshold keeps sleep", count_enable, 1'b0);
    check("R5 sleep wake_n with threshold", wake_n, 1'b1);

    // R7: host high exits after three edges
    host_line = 1'b1;
    step(2);
    check("R7 two edges still asleep", count_enable, 1'b0);
    step(1);
    check("R7 third edge running", count_enable, 1'b1);
    check("R2 wake_n after exit", wake_n, 1'b0);

    // R1: reset from sleep restores run mode with a cleared timer
    host_line = 1'b0; above_thr = 1'b0;
    step(3);
    ticks(11);
    check("R3 second sleep entry", count_enable, 1'b0);
    rst_n = 1'b0;
    step(1);
    check("R1 reset from sleep", count_enable, 1'b1);
    rst_n = 1'b1;
    step(1);
    ticks(10);
    check("R1 timer cleared by reset", count_enable, 1'b1);
    ticks(1);
    check("R1 full run needed after reset", count_enable, 1'b0);

    step(2);
    finish_run();
  end

endmodule